// File: doc/BRIEF.md
# Socket Status Change Detector

This block watches the card status lines of two card sockets. Each socket has five inputs: card detect, write protect, ready, and two battery-level lines. Every clock cycle the block compares the present status of each socket with a stored copy of the previous cycle's status. It then overwrites that copy. Each source that toggled and is not masked sets a sticky pending event bit for its socket. The status inputs must already be synchronous to the clock. Filtering of contact bounce is left to the logic that drives them.

A per-socket mode bit selects how the status lines are read. In memory-card mode, ready, battery dead (first battery line) and battery warning (second battery line) are separate events. In I/O-card mode, a change on the first battery line is reported as a card status-change event, and ready and the second battery line report nothing.

The host reaches the block through a small synchronous register port. Address bit 2 selects the socket and address bits 1:0 select one of four registers:
- live status (offset 0)
- pending events (offset 1, write ones to clear)
- source mask (offset 2)
- configuration (offset 3)

The interrupt output is active high and is driven actively in both states. It is the OR of every pending bit of both sockets, gated by a global enable bit.

Top module: `sts_change_det`

## Requirements
- R1: After reset all pending bits, all mask bits, both mode bits and the enable bit read 0, and the interrupt output is low.
- R2: An event is the XOR of the present status with the previous cycle's snapshot, so both rising and falling changes are reported once, and a steady level sets nothing.
- R3: In memory mode (configuration bit 0 = 0), a change on ready sets pending bit 2, on battery line 1 sets bit 3 (battery dead), and on battery line 2 sets bit 4 (battery warning). Pending bit 5 is never set.
- R4: In I/O mode (configuration bit 0 = 1), a change on battery line 1 sets pending bit 5 (status change), and changes on ready and battery line 2 set nothing.
- R5: In either mode, a change on card detect sets pending bit 0 and a change on write protect sets pending bit 1.
- R6: Mask register bit n (status bit order: 0 detect, 1 write protect, 2 ready, 3 battery 1, 4 battery 2) suppresses events from source n. Bit 3 also gates the I/O-mode status-change event. The value 0x1F suppresses every source.
- R7: Writing the pending register clears exactly the bits written as one. A bit being set by an event in the same cycle as its clear stays set.
- R8: The interrupt output is high exactly when the global enable (configuration bit 1) is set and at least one pending bit of either socket is set. The change is visible one clock edge after the status change or register write that causes it.
- R9: Each socket has its own snapshot, pending, mask and mode state, addressed by address bit 2. The enable bit is shared and reads back identically through both sockets.
- R10: Reading offset 0 returns the socket's present status inputs in the bit order of R6.
- R11: Snapshots reset to zero, so a card already present at reset raises exactly one detect event after reset, and only one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| status_i | input | 10 | Status lines, five per socket, socket 0 in bits 4:0 |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Bit 2 socket select, bits 1:0 register offset |
| wdata_i | input | 6 | Write data |
| rdata_o | output | 6 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Active-high change interrupt |

## Verification
The bench targets the following cases and the failure each one would expose:
- The mode-dependent remapping of the first battery line. A design that ignored the mode would report battery-dead instead of status-change, or would let ready and battery 2 through in I/O mode.
- Falling edges. A detector built on rising edges alone would miss these.
- The one-shot detect event after reset. A design that kept comparing against the reset value would raise the event again on every cycle.
- The case where an event and a clear of the same bit land together. A design that gave the clear priority would drop that event.
- Independence of the two sockets, with a shared enable bit. Cross-wired socket selection would show up as events or mode bits appearing in the wrong socket.

// File: rtl/sts_change_pkg.sv
`timescale 1ns/1ps
package sts_change_pkg;
  // status source positions
  localparam int SRC_CD   = 0;
  localparam int SRC_WP   = 1;
  localparam int SRC_RDY  = 2;
  localparam int SRC_BAT1 = 3;
  localparam int SRC_BAT2 = 4;
  localparam int SRC_W    = 5;
  // event bit positions
  localparam int EV_DET   = 0;
  localparam int EV_WP    = 1;
  localparam int EV_RDY   = 2;
  localparam int EV_BDEAD = 3;
  localparam int EV_BWARN = 4;
  localparam int EV_STCHG = 5;
  localparam int EV_W     = 6;

  typedef enum logic [1:0] {
    OFF_LIVE = 2'd0,
    OFF_PEND = 2'd1,
    OFF_MASK = 2'd2,
    OFF_CFG  = 2'd3
  } reg_off_e;
endpackage

// File: rtl/sts_chg_slice.sv
`timescale 1ns/1ps
module sts_chg_slice
  import sts_change_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  status_i,
  input  logic [SRC_W-1:0]  mask_i,
  input  logic              io_mode_i,
  input  logic [EV_W-1:0]   clr_i,
  output logic [EV_W-1:0]   pend_o
);
  logic [SRC_W-1:0] snap_q;
  logic [SRC_W-1:0] delta;
  logic [SRC_W-1:0] live_chg;
  logic [EV_W-1:0]  ev;
  logic [EV_W-1:0]  pend_d, pend_q;

  // next-state logic
  always_comb begin
    delta    = status_i ^ snap_q;
    live_chg = delta & ~mask_i;
    ev = '0;
    ev[EV_DET] = live_chg[SRC_CD];
    ev[EV_WP]  = live_chg[SRC_WP];
    if (io_mode_i) begin
      ev[EV_STCHG] = live_chg[SRC_BAT1];
    end else begin
      ev[EV_RDY]   = live_chg[SRC_RDY];
      ev[EV_BDEAD] = live_chg[SRC_BAT1];
      ev[EV_BWARN] = live_chg[SRC_BAT2];
    end
    pend_d = (pend_q & ~clr_i) | ev;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      pend_q <= '0;
    end else begin
      snap_q <= status_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  p_io_no_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_mode_i && !pend_q[EV_RDY] && !pend_q[EV_BWARN]) |=> (!pend_q[EV_RDY] && !pend_q[EV_BWARN]));
  p_mem_no_stchg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_mode_i && !pend_q[EV_STCHG]) |=> !pend_q[EV_STCHG]);
  p_masked_detect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i[SRC_CD] && !pend_q[EV_DET]) |=> !pend_q[EV_DET]);
  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((pend_q & $past(clr_i)) == ($past(ev) & $past(clr_i))));
  p_steady_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_i == snap_q) && (clr_i == '0)) |=> $stable(pend_q));
endmodule

// File: rtl/sts_host_regs.sv
`timescale 1ns/1ps
module sts_host_regs
  import sts_change_pkg::*;
#(
  parameter int NSOCK  = 2,
  parameter int DATA_W = EV_W,
  parameter int ADDR_W = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NSOCK-1:0][SRC_W-1:0]   status_i,
  input  logic [NSOCK-1:0][EV_W-1:0]    pend_i,
  output logic [NSOCK-1:0][SRC_W-1:0]   mask_o,
  output logic [NSOCK-1:0]              io_mode_o,
  output logic                          irq_en_o,
  output logic [NSOCK-1:0][EV_W-1:0]    clr_o,
  output logic [DATA_W-1:0]             rdata_o
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] sel;
  reg_off_e         off;
  logic             sel_ok;

  logic [NSOCK-1:0][SRC_W-1:0] mask_d, mask_q;
  logic [NSOCK-1:0]            mode_d, mode_q;
  logic                        en_d, en_q;
  logic                        mask_we, cfg_we, pend_we;

  assign sel    = addr_i[ADDR_W-1:2];
  assign off    = reg_off_e'(addr_i[1:0]);
  assign sel_ok = (int'(sel) < NSOCK);

  assign mask_we = wr_i && sel_ok && (off == OFF_MASK);
  assign cfg_we  = wr_i && sel_ok && (off == OFF_CFG);
  assign pend_we = wr_i && sel_ok && (off == OFF_PEND);

  // next-state logic
  always_comb begin
    mask_d = mask_q;
    mode_d = mode_q;
    en_d   = en_q;
    clr_o  = '0;
    for (int s = 0; s < NSOCK; s++) begin
      if (s == int'(sel)) begin
        if (mask_we) mask_d[s] = wdata_i[SRC_W-1:0];
        if (cfg_we)  mode_d[s] = wdata_i[0];
        if (pend_we) clr_o[s]  = wdata_i[EV_W-1:0];
      end
    end
    if (cfg_we) en_d = wdata_i[1];
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      mode_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_d;
      if (cfg_we) begin
        mode_q <= mode_d;
        en_q   <= en_d;
      end
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < NSOCK; s++) begin
      if (s == int'(sel)) begin
        case (off)
          OFF_LIVE: rdata_o[SRC_W-1:0] = status_i[s];
          OFF_PEND: rdata_o[EV_W-1:0]  = pend_i[s];
          OFF_MASK: rdata_o[SRC_W-1:0] = mask_q[s];
          OFF_CFG:  rdata_o[1:0]       = {en_q, mode_q[s]};
          default:  rdata_o            = '0;
        endcase
      end
    end
  end

  assign mask_o    = mask_q;
  assign io_mode_o = mode_q;
  assign irq_en_o  = en_q;

  p_mask_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_q));
  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(mode_q) && $stable(en_q)));
endmodule

// File: rtl/sts_change_det.sv
`timescale 1ns/1ps
module sts_change_det
  import sts_change_pkg::*;
#(
  parameter int NSOCK  = 2,
  parameter int DATA_W = EV_W,
  parameter int ADDR_W = $clog2(NSOCK) + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NSOCK*SRC_W-1:0]   status_i,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     irq_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NSOCK-1:0][SRC_W-1:0] status_v;
  logic [NSOCK-1:0][SRC_W-1:0] mask_v;
  logic [NSOCK-1:0]            io_mode_v;
  logic [NSOCK-1:0][EV_W-1:0]  clr_v;
  logic [NSOCK-1:0][EV_W-1:0]  pend_v;
  logic                        irq_en;

  assign status_v = status_i;

  sts_host_regs #(
    .NSOCK (NSOCK),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_int_n),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .status_i (status_v),
    .pend_i   (pend_v),
    .mask_o   (mask_v),
    .io_mode_o(io_mode_v),
    .irq_en_o (irq_en),
    .clr_o    (clr_v),
    .rdata_o  (rdata_o)
  );

  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    sts_chg_slice u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_int_n),
      .status_i (status_v[s]),
      .mask_i   (mask_v[s]),
      .io_mode_i(io_mode_v[s]),
      .clr_i    (clr_v[s]),
      .pend_o   (pend_v[s])
    );
  end

  assign irq_o = irq_en & (|pend_v);

  p_irq_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (wr_i && addr_i[1:0] == 2'd3 && !wdata_i[1]) |=> !irq_o);
  p_irq_needs_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    irq_o |-> (pend_v != '0));
endmodule

// File: tb/sts_change_det_test.sv
`timescale 1ns/1ps
module sts_change_det_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] status;
  logic       wr;
  logic [2:0] addr;
  logic [5:0] wdata;
  logic [5:0] rdata;
  logic       irq;

  typedef struct {
    logic [5:0] exp;
    bit         is_irq;
    string      tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sts_change_det uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .status_i(status),
    .wr_i    (wr),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  // monitor: compares design outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [5:0] act;
        it  = q.pop_front();
        act = it.is_irq ? {5'd0, irq} : rdata;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [5:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [5:0] e, input string t);
    addr = a;
    q.push_back('{e, 1'b0, t});
    @(negedge clk);
  endtask

  task automatic exp_irq(input logic e, input string t);
    q.push_back('{{5'd0, e}, 1'b1, t});
    @(negedge clk);
  endtask

  task automatic set_st(input int s, input logic [4:0] v);
    status[s*5 +: 5] = v;
    @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog (all requirements): got hang expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; status = 10'h001; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 / R1: reset state
    exp_rd(3'd1, 6'h01, "R11 detect after reset s0");
    exp_rd(3'd5, 6'h00, "R1 pending s1");
    exp_rd(3'd2, 6'h00, "R1 mask s0");
    exp_rd(3'd3, 6'h00, "R1 cfg s0");
    exp_irq(1'b0, "R1 irq low");
    wr_reg(3'd1, 6'h01);
    exp_rd(3'd1, 6'h00, "R7 clear detect");
    repeat (3) @(negedge clk);
    exp_rd(3'd1, 6'h00, "R11 one-shot");

    // R10 live status, R3/R5 memory mapping
    exp_rd(3'd0, 6'h01, "R10 live s0");
    set_st(1, 5'h1A);
    exp_rd(3'd4, 6'h1A, "R10 live s1");
    exp_rd(3'd5, 6'h1A, "R3 mem events s1");
    wr_reg(3'd5, 6'h3F);
    exp_rd(3'd5, 6'h00, "R7 clear all s1");

    // R8 interrupt
    wr_reg(3'd3, 6'h02);
    exp_irq(1'b0, "R8 enabled no pending");
    set_st(0, 5'h05);
    exp_rd(3'd1, 6'h04, "R3 ready event");
    exp_irq(1'b1, "R8 irq high");
    wr_reg(3'd1, 6'h04);
    exp_irq(1'b0, "R8 irq low after clear");

    // R2 falling edge
    set_st(0, 5'h01);
    exp_rd(3'd1, 6'h04, "R2 falling ready");
    wr_reg(3'd1, 6'h04);

    // R4 I/O mode
    wr_reg(3'd3, 6'h03);
    exp_rd(3'd3, 6'h03, "R4 cfg readback");
    set_st(0, 5'h1D);
    exp_rd(3'd1, 6'h20, "R4 io rising");
    wr_reg(3'd1, 6'h20);
    set_st(0, 5'h01);
    exp_rd(3'd1, 6'h20, "R4 io falling");
    wr_reg(3'd1, 6'h20);
    exp_rd(3'd1, 6'h00, "R7 clear stschg");

    // R6 masks, R5 write protect
    wr_reg(3'd3, 6'h02);
    wr_reg(3'd2, 6'h01);
    exp_rd(3'd2, 6'h01, "R6 mask readback");
    set_st(0, 5'h00);
    exp_rd(3'd1, 6'h00, "R6 masked detect");
    set_st(0, 5'h02);
    exp_rd(3'd1, 6'h02, "R5 write protect event");
    wr_reg(3'd1, 6'h02);
    wr_reg(3'd2, 6'h1F);
    set_st(0, 5'h1D);
    exp_rd(3'd1, 6'h00, "R6 mask all");
    exp_irq(1'b0, "R6 irq with mask all");
    exp_rd(3'd2, 6'h1F, "R6 mask all readback");

    // R9 socket independence
    set_st(1, 5'h1B);
    exp_rd(3'd5, 6'h01, "R9 s1 detect");
    exp_rd(3'd1, 6'h00, "R9 s0 untouched");
    exp_irq(1'b1, "R9 irq from s1");
    wr_reg(3'd7, 6'h03);
    exp_rd(3'd3, 6'h02, "R9 s0 mode kept");
    exp_rd(3'd7, 6'h03, "R9 s1 cfg");

    // R4 / R7 partial clear and set-wins
    set_st(1, 5'h13);
    exp_rd(3'd5, 6'h21, "R4 s1 stschg");
    wr_reg(3'd5, 6'h20);
    exp_rd(3'd5, 6'h01, "R7 partial clear");
    wr_reg(3'd5, 6'h00);
    exp_rd(3'd5, 6'h01, "R7 zero write");
    status[9:5] = 5'h12;
    addr = 3'd5; wdata = 6'h01; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    exp_rd(3'd5, 6'h01, "R7 set wins over clear");

    // R8 enable off
    wr_reg(3'd3, 6'h00);
    exp_irq(1'b0, "R8 disabled");
    exp_rd(3'd5, 6'h01, "R8 pending kept");
    wr_reg(3'd5, 6'h01);
    exp_rd(3'd5, 6'h00, "R7 final clear");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      report();
    end
  end
endmodule